// File: doc/BRIEF.md
# Pipeline Hazard Controller with Branch History

This block is the hazard controller of a five-stage in-order integer pipeline. It compares the source register indices of the instruction in decode with the destination of a load in execute. On a match it freezes fetch and decode for one cycle and turns the next execute slot into a bubble. When execute resolves a branch as taken, it squashes the two younger instructions by flushing the fetch/decode and decode/execute registers.

The block also keeps a table of 2-bit saturating branch-history counters. One PC selects the entry for the lookup, and the counter's upper bit comes out as a prediction. A second PC, that of the branch resolving in execute, selects the entry to train. The two indices are separate, so a lookup and an update can happen in the same cycle. The prediction only reports history. Steering fetch from it is left to the surrounding pipeline, and so are the datapath multiplexers.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_mem_read_i` is 1 and `ex_rd_i` is nonzero and equal to `id_rs1_i` or `id_rs2_i`, and no flush occurs, the block stalls: `pc_write_o`=0, `if_id_write_o`=0, `nop_sel_o`=1.
- R2: With no load-use match (execute is not a load, or its destination differs from both sources), `pc_write_o`=1, `if_id_write_o`=1 and `nop_sel_o`=0.
- R3: A load whose destination is register 0 never stalls, even when a source index is also 0.
- R4: `flush_o` is 1 exactly when `ex_br_valid_i` and `ex_br_taken_i` are both 1. A not-taken branch, or a taken flag with no valid branch, gives `flush_o`=0.
- R5: When a flush and a load-use match occur in the same cycle, the flush wins: `flush_o`=1, `pc_write_o`=1, `if_id_write_o`=1, `nop_sel_o`=0.
- R6: After reset every history counter holds 01 (weakly not taken), so `predict_o` is 0 for all entries.
- R7: Each valid branch resolution updates its counter at the next clock edge. A taken branch adds one, up to a maximum of 3. A not-taken branch subtracts one, down to a minimum of 0.
- R8: Both the lookup and the update entry are selected by PC bits [5:2]. Other PC bits do not affect the selection, and an update changes no other entry.
- R9: `predict_o` is bit 1 of the counter selected by `fetch_pc_i`. A lookup in the same cycle as an update of that entry returns the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | 5 | Decode-stage first source register |
| id_rs2_i | input | 5 | Decode-stage second source register |
| ex_rd_i | input | 5 | Execute-stage destination register |
| ex_mem_read_i | input | 1 | Execute-stage instruction is a load |
| ex_br_valid_i | input | 1 | A branch resolves in execute this cycle |
| ex_br_taken_i | input | 1 | Resolved branch outcome is taken |
| ex_br_pc_i | input | 64 | PC of the resolving branch (update index) |
| fetch_pc_i | input | 64 | PC used for the history lookup |
| pc_write_o | output | 1 | PC write enable |
| if_id_write_o | output | 1 | Fetch/decode register write enable |
| nop_sel_o | output | 1 | Zero the control bundle entering decode/execute |
| flush_o | output | 1 | Clear fetch/decode and decode/execute registers |
| predict_o | output | 1 | Predicted taken for the looked-up entry |

## Verification
The bench builds the block with its default parameters: 5-bit register indices, a 64-bit PC and a 16-entry table indexed from bit 2. With these values every table entry is reachable after reset, so the reset value of each one can be checked. One entry is driven past both saturation points and back, to show the hysteresis. PCs that differ only above bit 5 or below bit 2 show which bits select the entry.

// File: rtl/hdu_pkg.sv
package hdu_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_ST  = 2'b11;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_ST) nxt = cur + 2'd1;
    else if (!taken && cur != CTR_SNT) nxt = cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/hdu_load_use.sv
module hdu_load_use #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] rs1_i,
  input  logic [REG_W-1:0] rs2_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             is_load_i,
  output logic             hazard_o
);
  logic rd_live;
  assign rd_live  = is_load_i && (rd_i != '0);
  assign hazard_o = rd_live && ((rd_i == rs1_i) || (rd_i == rs2_i));

  always_comb begin
    a_r3_x0_never_hazard: assert (!(hazard_o && rd_i == '0));
  end
endmodule

// File: rtl/hdu_bht.sv
module hdu_bht
  import hdu_pkg::*;
#(
  parameter int unsigned PC_W    = 64,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] look_pc_i,
  input  logic            upd_valid_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_pc_i,
  output logic            pred_o
);
  localparam int unsigned N_ENT = 1 << IDX_W;

  logic [IDX_W-1:0] look_idx, upd_idx;
  ctr_t             cnt_q [N_ENT];
  ctr_t             upd_next;
  logic             unused_pc_bits;

  assign look_idx       = look_pc_i[IDX_LSB +: IDX_W];
  assign upd_idx        = upd_pc_i[IDX_LSB +: IDX_W];
  assign unused_pc_bits = ^{look_pc_i, upd_pc_i};
  assign upd_next       = ctr_step(cnt_q[upd_idx], upd_taken_i);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[g] <= CTR_WNT;
      else if (upd_valid_i && upd_idx == IDX_W'(g)) cnt_q[g] <= upd_next;
    end
  end

  assign pred_o = cnt_q[look_idx][1];

  a_r7_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && cnt_q[upd_idx] != CTR_ST)
      |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) + 2'd1);
  a_r7_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && cnt_q[upd_idx] != CTR_SNT)
      |=> cnt_q[$past(upd_idx)] == $past(cnt_q[upd_idx]) - 2'd1);
  a_r7_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && cnt_q[upd_idx] == CTR_ST)
      |=> cnt_q[$past(upd_idx)] == CTR_ST);
  a_r7_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && cnt_q[upd_idx] == CTR_SNT)
      |=> cnt_q[$past(upd_idx)] == CTR_SNT);
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(cnt_q[look_idx]) || look_idx != $past(look_idx));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned PC_W    = 64,
  parameter int unsigned BHT_IW  = 4,
  parameter int unsigned BHT_LSB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_mem_read_i,
  input  logic             ex_br_valid_i,
  input  logic             ex_br_taken_i,
  input  logic [PC_W-1:0]  ex_br_pc_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic             pc_write_o,
  output logic             if_id_write_o,
  output logic             nop_sel_o,
  output logic             flush_o,
  output logic             predict_o
);
  logic lu_hazard, stall;

  hdu_load_use #(.REG_W(REG_W)) u_lu (
    .rs1_i     (id_rs1_i),
    .rs2_i     (id_rs2_i),
    .rd_i      (ex_rd_i),
    .is_load_i (ex_mem_read_i),
    .hazard_o  (lu_hazard)
  );

  assign flush_o       = ex_br_valid_i && ex_br_taken_i;
  assign stall         = lu_hazard && !flush_o;  // squash makes the stall moot
  assign pc_write_o    = !stall;
  assign if_id_write_o = !stall;
  assign nop_sel_o     = stall;

  hdu_bht #(.PC_W(PC_W), .IDX_W(BHT_IW), .IDX_LSB(BHT_LSB)) u_bht (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_pc_i   (fetch_pc_i),
    .upd_valid_i (ex_br_valid_i),
    .upd_taken_i (ex_br_taken_i),
    .upd_pc_i    (ex_br_pc_i),
    .pred_o      (predict_o)
  );

  a_r1_stall_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_sel_o |-> (!pc_write_o && !if_id_write_o));
  a_r1_match_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_mem_read_i && ex_rd_i != '0 && ex_rd_i == id_rs1_i && !flush_o) |-> nop_sel_o);
  a_r2_no_load_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_mem_read_i |-> (pc_write_o && if_id_write_o && !nop_sel_o));
  a_r5_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (pc_write_o && !nop_sel_o));
  a_r4_no_branch_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_br_valid_i |-> !flush_o);
endmodule

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rs1 = '0, rs2 = '0, rd = '0;
  logic        ld = 1'b0, bv = 1'b0, bt = 1'b0;
  logic [63:0] bpc = '0, fpc = '0;
  logic        pcw, ifw, nop, fl, pred;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] model [16];
  bit         done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pipe_hazard_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .id_rs1_i(rs1), .id_rs2_i(rs2), .ex_rd_i(rd),
    .ex_mem_read_i(ld), .ex_br_valid_i(bv), .ex_br_taken_i(bt), .ex_br_pc_i(bpc),
    .fetch_pc_i(fpc), .pc_write_o(pcw), .if_id_write_o(ifw), .nop_sel_o(nop),
    .flush_o(fl), .predict_o(pred)
  );

  // expected vector: {pc_write, if_id_write, nop_sel, flush, predict}
  task automatic step(input logic [4:0] s1, input logic [4:0] s2, input logic [4:0] d,
                      input logic l, input logic v, input logic t,
                      input logic [63:0] upc, input logic [63:0] lpc, input string tag);
    logic lu, f, st, p;
    @(posedge clk); #1;
    rs1 = s1; rs2 = s2; rd = d; ld = l; bv = v; bt = t; bpc = upc; fpc = lpc;
    lu = l && d != 0 && (d == s1 || d == s2);
    f  = v && t;
    st = lu && !f;
    p  = model[lpc[5:2]][1];
    exp_q.push_back({!st, !st, st, f, p});
    tag_q.push_back(tag);
    if (v) begin
      if (t && model[upc[5:2]] != 2'd3) model[upc[5:2]] = model[upc[5:2]] + 2'd1;
      else if (!t && model[upc[5:2]] != 2'd0) model[upc[5:2]] = model[upc[5:2]] - 2'd1;
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if ({pcw, ifw, nop, fl, pred} !== e) begin
        errors++;
        $display("FAIL %s got {pcw,ifw,nop,fl,pred}=%b expected %b", tg, {pcw, ifw, nop, fl, pred}, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 2'd1;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R6: every entry resets to weakly not taken
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 0, 0, 64'(i * 4), "R6 reset entry");
    // R1 / R2 / R3 load-use
    step(5, 9, 5, 1, 0, 0, 0, 0, "R1 rs1 match");
    step(9, 7, 7, 1, 0, 0, 0, 0, "R1 rs2 match");
    step(5, 5, 5, 0, 0, 0, 0, 0, "R2 not a load");
    step(4, 6, 8, 1, 0, 0, 0, 0, "R2 load no match");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R3 load to x0");
    step(3, 0, 0, 1, 0, 0, 0, 0, "R3 load to x0 rs2");
    // R4 flush
    step(0, 0, 0, 0, 1, 1, 64'h80, 0, "R4 taken flush");
    step(0, 0, 0, 0, 1, 0, 64'h80, 0, "R4 not taken");
    step(0, 0, 0, 0, 0, 1, 64'h80, 0, "R4 taken without valid");
    // R5 flush over stall
    step(5, 2, 5, 1, 1, 1, 64'h84, 0, "R5 flush wins");
    step(5, 2, 5, 1, 0, 0, 0, 0, "R1 stall after flush cycle");
    // R7 / R9: train entry 3 up, lookup same entry in same cycle sees old value
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, 64'h0C, 64'h0C, "R7 R9 taken train");
    step(0, 0, 0, 0, 0, 0, 0, 64'h0C, "R7 saturated high");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, 64'h0C, 64'h0C, "R7 not taken train");
    step(0, 0, 0, 0, 0, 0, 0, 64'h0C, "R7 saturated low");
    step(0, 0, 0, 0, 1, 1, 64'h0C, 64'h0C, "R7 up from zero");
    step(0, 0, 0, 0, 1, 1, 64'h0C, 64'h0C, "R7 up to weak taken");
    step(0, 0, 0, 0, 0, 0, 0, 64'h0C, "R9 predict taken");
    // R8: high and low PC bits do not select
    step(0, 0, 0, 0, 1, 1, 64'hF000_0018, 64'h1C, "R8 upper bits update idx6");
    step(0, 0, 0, 0, 1, 1, 64'h18, 64'h1B, "R8 low bits lookup idx6");
    step(0, 0, 0, 0, 0, 0, 0, 64'h5_0018, "R8 aliased lookup idx6");
    step(0, 0, 0, 0, 0, 0, 0, 64'h1C, "R8 neighbour untouched");
    step(0, 0, 0, 0, 0, 0, 0, 64'h14, "R8 other neighbour untouched");
    @(posedge clk); @(posedge clk);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule